// File: doc/BRIEF.md
# Byte-Wide USB Data CRC16 Engine

This block computes the 16-bit check value used on USB data packets, absorbing one byte per clock. The same engine serves both directions. The packet sequencer drives three things: an idle level, a byte strobe and the byte itself. While the sequencer is idle, the register is reloaded with all ones. Each strobed byte advances the register by the equivalent of eight single-bit LFSR steps, which a flat XOR network performs in one cycle.

On transmit, the block presents the check value already in its on-wire form: the register bits are reversed and inverted. The value goes out low byte first. On receive, the data bytes and then the two received check bytes pass through the register. A flag reports whether the fixed good-packet residue is present.

Bit stuffing, line coding, framing and packet identifiers belong to neighbouring blocks.

Top module: `usb_crc16_byte`

## Requirements
- R1: A synchronous, active-high `rst` sets the register to 16'hFFFF. After the clock edge, `crc_tx` reads 16'h0000 and `residue_ok` reads 0.
- R2: While `idle` is high at a clock edge, the register reloads to 16'hFFFF, even if `byte_stb` is also high. The strobed byte is then ignored.
- R3: When `idle` is low and `byte_stb` is low, the register holds, so `crc_tx` and `residue_ok` do not change.
- R4: When `idle` is low and `byte_stb` is high, the next register value equals eight serial steps over `byte_in`. The steps take bit 0 first. Each step computes feedback = reg[15] XOR bit, shifts left by one, and XORs in 16'h8005 when the feedback is 1.
- R5: `crc_tx[k]` equals the inverse of `reg[15-k]` for every k. `crc_tx[7:0]` is the byte sent first.
- R6: `residue_ok` is 1 exactly when the register equals 16'h800D (16'b1000000000001101).
- R7: A packet of 0 to 64 data bytes, followed by its own `crc_tx` low byte and then high byte, leaves `residue_ok` at 1. Flipping any single bit of that stream leaves `residue_ok` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle | input | 1 | Sequencer idle; reloads the seed |
| byte_stb | input | 1 | Byte on `byte_in` is valid this cycle |
| byte_in | input | 8 | Data or received check byte, bit 0 first on the wire |
| crc_tx | output | 16 | Reversed, inverted register; low byte sent first |
| residue_ok | output | 1 | Register holds the good-packet residue |

## Verification
The hardest condition to reach from the ports is the residue match. It appears only after a packet has been followed by its own correctly formed check bytes, and it must then vanish for any single corrupted bit. The stimulus builds every packet length from 0 to 64 bytes. Each packet's check bytes are taken from the block's own transmit output and fed straight back in. A second pass replays each stream with one bit flipped, and the flipped position is walked across the data and check fields.

// File: rtl/usb_crc16_pkg.sv
package usb_crc16_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;
  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Eight serial LFSR steps, data bit 0 first
  function automatic crc_t crc_steps(crc_t cur, byte_t d, crc_t poly);
    crc_t r;
    logic fb;
    r = cur;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

  // Which register bits feed output bit j
  function automatic crc_t state_taps(int j, crc_t poly);
    crc_t m;
    crc_t v;
    m = '0;
    for (int i = 0; i < CRC_W; i++) begin
      v = crc_steps(crc_t'(1) << i, '0, poly);
      m[i] = v[j];
    end
    return m;
  endfunction

  // Which data bits feed output bit j
  function automatic byte_t data_taps(int j, crc_t poly);
    byte_t m;
    crc_t  v;
    m = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      v = crc_steps('0, byte_t'(1) << i, poly);
      m[i] = v[j];
    end
    return m;
  endfunction

  function automatic crc_t wire_form(crc_t r);
    crc_t o;
    for (int k = 0; k < CRC_W; k++) o[k] = ~r[CRC_W-1-k];
    return o;
  endfunction
endpackage

// File: rtl/usb_crc16_xor_net.sv
module usb_crc16_xor_net
  import usb_crc16_pkg::*;
#(
  parameter crc_t POLY = 16'h8005
) (
  input  crc_t  cur,
  input  byte_t din,
  output crc_t  nxt
);
  for (genvar j = 0; j < CRC_W; j++) begin : g_bit
    localparam crc_t  STAP = state_taps(j, POLY);
    localparam byte_t DTAP = data_taps(j, POLY);
    assign nxt[j] = (^(cur & STAP)) ^ (^(din & DTAP));
  end
endmodule

// File: rtl/usb_crc16_state.sv
module usb_crc16_state
  import usb_crc16_pkg::*;
#(
  parameter crc_t POLY = 16'h8005,
  parameter crc_t SEED = 16'hFFFF
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  idle,
  input  logic  byte_stb,
  input  byte_t byte_in,
  input  crc_t  nxt,
  output crc_t  crc_q
);
  logic reload, advance;
  assign reload  = idle;
  assign advance = byte_stb && !idle;

  always_ff @(posedge clk) begin
    if (rst || reload) crc_q <= SEED;
    else if (advance)  crc_q <= nxt;
  end

  assert_reset_seed_R1: assert property (@(posedge clk) rst |=> crc_q == SEED);
  assert_idle_seed_R2: assert property (@(posedge clk) disable iff (rst)
    reload |=> crc_q == SEED);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!idle && !byte_stb) |=> $stable(crc_q));
  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    advance |=> crc_q == crc_steps($past(crc_q), $past(byte_in), POLY));
endmodule

// File: rtl/usb_crc16_byte.sv
module usb_crc16_byte
  import usb_crc16_pkg::*;
#(
  parameter crc_t POLY    = 16'h8005,
  parameter crc_t SEED    = 16'hFFFF,
  parameter crc_t RESIDUE = 16'h800D
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        idle,
  input  logic        byte_stb,
  input  logic [7:0]  byte_in,
  output logic [15:0] crc_tx,
  output logic        residue_ok
);
  crc_t crc_q, crc_nxt;

  usb_crc16_xor_net #(.POLY(POLY)) u_net (
    .cur(crc_q), .din(byte_in), .nxt(crc_nxt)
  );

  usb_crc16_state #(.POLY(POLY), .SEED(SEED)) u_state (
    .clk(clk), .rst(rst), .idle(idle), .byte_stb(byte_stb),
    .byte_in(byte_in), .nxt(crc_nxt), .crc_q(crc_q)
  );

  assign crc_tx     = wire_form(crc_q);
  assign residue_ok = (crc_q == RESIDUE);

  assert_tx_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!idle && !byte_stb) |=> $stable(crc_tx));
  assert_residue_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!idle && !byte_stb) |=> $stable(residue_ok));
  assert_idle_flag_R6: assert property (@(posedge clk) disable iff (rst)
    idle |=> !residue_ok && crc_tx == 16'h0000);
endmodule

// File: tb/usb_crc16_byte_test.sv
module usb_crc16_byte_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1, idle = 1, byte_stb = 0;
  logic [7:0] byte_in = 0;
  logic [15:0] crc_tx;
  logic residue_ok;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  usb_crc16_byte uut (
    .clk(clk), .rst(rst), .idle(idle), .byte_stb(byte_stb),
    .byte_in(byte_in), .crc_tx(crc_tx), .residue_ok(residue_ok)
  );

  // Bit-serial reference: one bit at a time, bit 0 of each byte first
  function automatic logic [15:0] ref_bit(logic [15:0] r, logic b);
    logic msb;
    msb = r[15];
    r = r << 1;
    if (msb ^ b) r = r ^ 16'h8005;
    return r;
  endfunction

  function automatic logic [15:0] ref_byte(logic [15:0] r, logic [7:0] d);
    for (int i = 0; i < 8; i++) r = ref_bit(r, d[i]);
    return r;
  endfunction

  function automatic logic [15:0] on_wire(logic [15:0] r);
    logic [15:0] o;
    for (int k = 0; k < 16; k++) o[k] = !r[15-k];
    return o;
  endfunction

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    byte_stb = 1; byte_in = b;
    @(negedge clk);
    byte_stb = 0; byte_in = $urandom;
  endtask

  task automatic go_idle();
    @(negedge clk); idle = 1;
    @(negedge clk); idle = 0;
  endtask

  logic [7:0] pkt [0:65];
  logic [15:0] model;

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(crc_tx == 16'h0000 && !residue_ok, "R1 reset", crc_tx, 16'h0000);
    idle = 0;
    put(8'hA5);
    check(crc_tx == on_wire(ref_byte(16'hFFFF, 8'hA5)), "R4 first byte", crc_tx, on_wire(ref_byte(16'hFFFF, 8'hA5)));
    // R2: idle wins over strobe
    @(negedge clk); idle = 1; byte_stb = 1; byte_in = 8'h3C;
    @(negedge clk); idle = 0; byte_stb = 0;
    check(crc_tx == 16'h0000, "R2 idle priority", crc_tx, 16'h0000);
    // R3: no strobe, no change
    repeat (4) @(negedge clk);
    check(crc_tx == 16'h0000 && !residue_ok, "R3 hold", crc_tx, 16'h0000);

    for (int pass = 0; pass < 2; pass++) begin
      for (int len = 0; len <= 64; len++) begin
        int nbits, flip;
        logic [15:0] good, held;
        for (int i = 0; i < len; i++) pkt[i] = $urandom;
        model = 16'hFFFF;
        for (int i = 0; i < len; i++) model = ref_byte(model, pkt[i]);
        good = on_wire(model);
        pkt[len] = good[7:0];
        pkt[len+1] = good[15:8];
        nbits = (len + 2) * 8;
        flip = (len * 37 + 5) % nbits;
        if (pass == 1) pkt[flip/8][flip%8] = !pkt[flip/8][flip%8];
        go_idle();
        model = 16'hFFFF;
        for (int i = 0; i < len + 2; i++) begin
          put(pkt[i]);
          model = ref_byte(model, pkt[i]);
          check(crc_tx == on_wire(model), "R4 R5 step", crc_tx, on_wire(model));
          check(residue_ok == (model == 16'h800D), "R6 flag", {15'd0, residue_ok}, {15'd0, model == 16'h800D});
          if (i % 7 == 3) begin
            held = crc_tx;
            repeat (2) @(negedge clk);
            check(crc_tx == held, "R3 gap hold", crc_tx, held);
          end
        end
        if (pass == 0)
          check(residue_ok, "R7 good packet", {15'd0, residue_ok}, 16'd1);
        else
          check(!residue_ok, "R7 flipped bit", {15'd0, residue_ok}, 16'd0);
      end
    end

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule